// File: doc/BRIEF.md
# Programmable Raster Window Pulse Generator

This block drives four pulse outputs, each placed in the video raster by a rectangular window. The window is set by a horizontal start and stop pixel and a vertical start and stop line. A pixel counter restarts on each horizontal sync leading-edge strobe and a line counter restarts on each vertical sync leading-edge strobe, so every position is measured from those two edges. The upstream timing generator supplies the strobes. This block does not produce them.

Each output can be merged with the raw window of the output just below it through AND, OR or XOR. Its polarity is then set on its own. This allows shapes such as a porch pulse limited to active lines. Settings are written through a simple register port into a shadow bank. The whole bank moves to the live copy at the next vertical sync strobe, so a frame never changes shape part way through.

The register port is plain control: there is no data stream and no back-pressure. A write completes in the cycle where `wr_en` is high.

Top module: `raster_pulse_gen`

## Requirements
- R1: The pixel counter becomes 0 on the cycle after `hs_lead` and otherwise increments by one per clock. The line counter becomes 1 after `vs_lead` and otherwise increments after each `hs_lead`; `vs_lead` wins when both are high.
- R2: The horizontal window of an output is open when h_start <= pixel < h_stop, so h_start >= h_stop never opens it.
- R3: The vertical window is open when v_start <= line <= v_stop, both bounds inclusive; v_start = v_stop selects exactly one line.
- R4: With combine code 0 (none), raw output k is the AND of its own horizontal and vertical windows.
- R5: Combine codes 1, 2 and 3 give AND, OR and XOR of output k's raw window with output k-1's raw window. Output 0 ignores its combine code.
- R6: The polarity bit of an output inverts it after the combine stage.
- R7: Writes land in a shadow bank. The live settings copy the shadow only on a clock where `vs_lead` is high, and a write on that same clock waits for the following strobe.
- R8: `pulse_o` is registered: it reflects the counters and live settings from before the clock edge. Reset clears the outputs, the counters and both banks.
- R9: Address 4k+0/1/2/3 holds h_start, h_stop, v_start and v_stop of output k. Address 16 holds the polarity bits in [3:0] and output k's combine code in bits [5+2k:4+2k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_lead | input | 1 | One-cycle strobe at the horizontal sync leading edge |
| vs_lead | input | 1 | One-cycle strobe at the vertical sync leading edge |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| pulse_o | output | 4 | The four window pulse outputs |

## Verification
The bound checker checks the following on every cycle:
- the counter restart and step rules;
- that the live settings stay frozen between vertical strobes;
- that an output with an empty horizontal window or an inverted vertical range sits at its polarity level.

The shapes of the combined pulses, the exact edges of each window, and the delayed effect of a mid-frame write show only in the bench's scenarios. The bench compares every output against a model built from the requirements across whole frames.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  parameter int unsigned N_OUT  = 4;
  parameter int unsigned PIX_W  = 12;
  parameter int unsigned LINE_W = 11;
  parameter int unsigned DATA_W = 16;
  localparam int unsigned IDX_W     = $clog2(N_OUT);
  localparam int unsigned ADDR_W    = IDX_W + 3;
  localparam int unsigned CTRL_ADDR = 4 * N_OUT;

  typedef enum logic [1:0] {
    CMB_NONE = 2'd0,
    CMB_AND  = 2'd1,
    CMB_OR   = 2'd2,
    CMB_XOR  = 2'd3
  } cmb_e;

  typedef struct packed {
    logic [PIX_W-1:0]  h_on;
    logic [PIX_W-1:0]  h_off;
    logic [LINE_W-1:0] v_on;
    logic [LINE_W-1:0] v_off;
  } win_t;

  typedef struct packed {
    win_t [N_OUT-1:0]       win;
    logic [N_OUT-1:0][1:0]  cmb;
    logic [N_OUT-1:0]       inv;
  } cfg_t;
endpackage

// File: rtl/rpg_counters.sv
module rpg_counters
  import rpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_lead,
  input  logic              vs_lead,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      if (hs_lead) pix_cnt <= '0;
      else         pix_cnt <= pix_cnt + 1'b1;
      if (vs_lead)      line_cnt <= LINE_W'(1);
      else if (hs_lead) line_cnt <= line_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rpg_cfg_regs.sv
module rpg_cfg_regs
  import rpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_lead,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg_act
);
  cfg_t              shadow;
  logic [IDX_W-1:0]  sel;
  logic [1:0]        fld;

  assign sel = wr_addr[2 +: IDX_W];
  assign fld = wr_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow  <= '0;
      cfg_act <= '0;
    end else begin
      if (wr_en) begin
        if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
          shadow.inv <= wr_data[N_OUT-1:0];
          for (int k = 0; k < N_OUT; k++)
            shadow.cmb[k] <= wr_data[N_OUT + 2*k +: 2];
        end else if (wr_addr < ADDR_W'(CTRL_ADDR)) begin
          case (fld)
            2'd0: shadow.win[sel].h_on  <= wr_data[PIX_W-1:0];
            2'd1: shadow.win[sel].h_off <= wr_data[PIX_W-1:0];
            2'd2: shadow.win[sel].v_on  <= wr_data[LINE_W-1:0];
            default: shadow.win[sel].v_off <= wr_data[LINE_W-1:0];
          endcase
        end
      end
      if (vs_lead) cfg_act <= shadow;
    end
  end
endmodule

// File: rtl/rpg_window.sv
module rpg_window
  import rpg_pkg::*;
(
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  win_t              win,
  output logic              raw
);
  logic h_open, v_open;
  assign h_open = (pix_cnt >= win.h_on) && (pix_cnt < win.h_off);
  assign v_open = (line_cnt >= win.v_on) && (line_cnt <= win.v_off);
  assign raw    = h_open && v_open;
endmodule

// File: rtl/rpg_combine.sv
module rpg_combine
  import rpg_pkg::*;
(
  input  logic [N_OUT-1:0]      raw,
  input  logic [N_OUT-1:0][1:0] cmb,
  input  logic [N_OUT-1:0]      inv,
  output logic [N_OUT-1:0]      shaped
);
  logic [N_OUT-1:0] merged;

  assign merged[0] = raw[0];

  for (genvar k = 1; k < N_OUT; k++) begin : g_cmb
    always_comb begin
      case (cmb_e'(cmb[k]))
        CMB_AND: merged[k] = raw[k] & raw[k-1];
        CMB_OR:  merged[k] = raw[k] | raw[k-1];
        CMB_XOR: merged[k] = raw[k] ^ raw[k-1];
        default: merged[k] = raw[k];
      endcase
    end
  end

  assign shaped = merged ^ inv;
endmodule

// File: rtl/raster_pulse_gen.sv
module raster_pulse_gen
  import rpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_lead,
  input  logic              vs_lead,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_OUT-1:0]  pulse_o
);
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  cfg_t              cfg_act;
  logic [N_OUT-1:0]  raw;
  logic [N_OUT-1:0]  shaped;

  rpg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  rpg_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .vs_lead(vs_lead), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg_act(cfg_act)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_win
    rpg_window u_win (
      .pix_cnt(pix_cnt), .line_cnt(line_cnt), .win(cfg_act.win[k]), .raw(raw[k])
    );
  end

  rpg_combine u_cmb (
    .raw(raw), .cmb(cfg_act.cmb), .inv(cfg_act.inv), .shaped(shaped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_o <= '0;
    else        pulse_o <= shaped;
  end
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker
  import rpg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hs_lead,
  input logic              vs_lead,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input cfg_t              cfg_act,
  input logic [N_OUT-1:0]  pulse_o
);
  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lead |=> pix_cnt == '0); // R1
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_lead |=> pix_cnt == PIX_W'($past(pix_cnt) + 1'b1)); // R1
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> line_cnt == LINE_W'(1)); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_lead |=> $stable(cfg_act)); // R7
  AST_EMPTY_HWIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.win[0].h_on >= cfg_act.win[0].h_off) |=> pulse_o[0] == $past(cfg_act.inv[0])); // R2
  AST_EMPTY_VWIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.win[0].v_on > cfg_act.win[0].v_off) |=> pulse_o[0] == $past(cfg_act.inv[0])); // R3
endmodule

bind raster_pulse_gen rpg_checker u_rpg_checker (
  .clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt), .cfg_act(cfg_act), .pulse_o(pulse_o)
);

// File: tb/tb_raster_pulse_gen.sv
module tb_raster_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 20;
  localparam int FRAME_LEN  = 240;
  localparam int NV         = 8;
  // idx, h_on, h_off, v_on, v_off, combine, polarity, requirement tag
  localparam int VEC [NV][8] = '{
    '{0,  2,  8,  2,  5, 0, 0, 4},
    '{1,  5, 15,  1, 12, 1, 0, 5},
    '{2,  0, 20,  3,  3, 2, 1, 6},
    '{3, 10, 12,  4,  9, 3, 0, 5},
    '{0,  7,  7,  1, 12, 3, 1, 2},
    '{1,  0,  4,  6,  4, 0, 0, 3},
    '{2, 19, 20, 12, 12, 1, 0, 5},
    '{3,  0, 20,  1, 12, 0, 1, 6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs_lead = 1'b0, vs_lead = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pulse_o;

  raster_pulse_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    chk_en = 1'b0, done = 1'b0;
  string cur_req = "R8";
  logic [15:0] ctrl = '0;

  // reference model from the requirements
  int   m_pix, m_line;
  int   sh_w [4][4], ac_w [4][4];
  logic [15:0] sh_c, ac_c;
  logic [3:0]  exp_q;

  function automatic logic [3:0] model_out();
    logic [3:0] raw, res;
    for (int k = 0; k < 4; k++)
      raw[k] = (m_pix >= ac_w[k][0]) && (m_pix < ac_w[k][1]) &&
               (m_line >= ac_w[k][2]) && (m_line <= ac_w[k][3]);
    res[0] = raw[0];
    for (int k = 1; k < 4; k++)
      case (ac_c[4+2*k +: 2])
        2'd1: res[k] = raw[k] & raw[k-1];
        2'd2: res[k] = raw[k] | raw[k-1];
        2'd3: res[k] = raw[k] ^ raw[k-1];
        default: res[k] = raw[k];
      endcase
    return res ^ ac_c[3:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pix <= 0; m_line <= 0; exp_q <= '0; sh_c <= '0; ac_c <= '0;
      for (int k = 0; k < 4; k++)
        for (int f = 0; f < 4; f++) begin sh_w[k][f] <= 0; ac_w[k][f] <= 0; end
    end else begin
      exp_q  <= model_out();
      m_pix  <= hs_lead ? 0 : (m_pix + 1) % 4096;
      m_line <= vs_lead ? 1 : (hs_lead ? (m_line + 1) % 2048 : m_line);
      if (wr_en) begin
        if (wr_addr == 5'd16) sh_c <= wr_data;
        else if (wr_addr < 5'd16) sh_w[wr_addr[3:2]][wr_addr[1:0]] <= int'(wr_data[10:0]);
      end
      if (vs_lead) begin
        ac_c <= sh_c;
        for (int k = 0; k < 4; k++)
          for (int f = 0; f < 4; f++) ac_w[k][f] <= sh_w[k][f];
      end
    end
  end

  // raster strobes
  int rcyc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      rcyc = 0; hs_lead <= 1'b0; vs_lead <= 1'b0;
    end else begin
      hs_lead <= (rcyc % LINE_LEN) == 0;
      vs_lead <= (rcyc % FRAME_LEN) == 0;
      rcyc = rcyc + 1;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && chk_en && !done) begin
      n_chk++;
      if (pulse_o !== exp_q) begin
        n_fail++;
        $display("FAIL %s: pulse_o actual=%b expected=%b at %0t", cur_req, pulse_o, exp_q, $time);
      end
    end
  end

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= 5'(addr); wr_data <= 16'(data);
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic set_out(input int idx, input int hon, input int hoff,
                         input int von, input int voff, input int mode, input int pol);
    wr(4*idx + 0, hon);
    wr(4*idx + 1, hoff);
    wr(4*idx + 2, von);
    wr(4*idx + 3, voff);
    ctrl[idx]         = pol[0];
    ctrl[4+2*idx +: 2] = mode[1:0];
    wr(16, ctrl);
  endtask

  function automatic string tag(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      9: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (4) @(negedge clk);
    check(pulse_o, 4'b0000, "R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;
    // R7: writes before any vertical strobe are not live yet (strobe at first cycle only)
    repeat (3) @(negedge clk);
    cur_req = "R7";
    set_out(0, 0, 20, 1, 12, 0, 1);
    repeat (30) @(negedge clk);
    check(pulse_o, 4'b0000, "R7");
    repeat (FRAME_LEN) @(negedge clk);
    // vector table
    for (int i = 0; i < NV; i++) begin
      cur_req = tag(VEC[i][7]);
      set_out(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);
      repeat (2*FRAME_LEN) @(negedge clk);
    end
    // R9: control word bit positions, all windows empty, all polarities set
    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin wr(4*k, 0); wr(4*k + 1, 0); end
    ctrl = 16'h000F;
    wr(16, ctrl);
    repeat (FRAME_LEN + 5) @(negedge clk);
    check(pulse_o, 4'b1111, "R9");
    // R1: single-pixel window at pixel 0 of line 1
    cur_req = "R1";
    ctrl = 16'h0000;
    wr(16, ctrl);
    set_out(0, 0, 1, 1, 1, 0, 0);
    repeat (2*FRAME_LEN) @(negedge clk);
    // R7: mid-frame write of a full window stays invisible until next strobe
    cur_req = "R7";
    while (!vs_lead) @(negedge clk);
    repeat (40) @(negedge clk);
    set_out(3, 0, 20, 1, 12, 0, 0);
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      check({3'b000, pulse_o[3]}, 4'b0000, "R7");
    end
    repeat (FRAME_LEN) @(negedge clk);
    check({3'b000, pulse_o[3]}, 4'b0001, "R7");
    finish_run();
  end
endmodule